// File: doc/BRIEF.md
# Boundary-Scan Wrapped Dual Register Bank

The block holds two independent banks of `DATA_W` edge-triggered data flip-flops. Each bank has its own rising-edge clock and its own active-low output enable. Outputs are modelled as a data value plus an active-high drive enable. When the drive enable is low, the bank's outputs are at high impedance. A serial test chain of `4*DATA_W+6` cells wraps both banks. The chain observes every system input. It can also observe and override every system output and the two internal active-high enable nets.

An external test-access controller sequences the chain. It supplies the capture, shift and update strobes and a two-bit mode code. Capture and shift happen on the rising edge of the test clock. The update latches load on the falling edge. In the two drive modes, the update latches own the output data and the output enables. Test-logic reset clears both the shift stage and the latches, and the cleared latches leave every output disabled.

Top module: `bscan_dual_bank`

## Requirements
- R1: On a rising edge of its own clock, a bank stores its data inputs. The other bank's contents are unchanged.
- R2: In mode code 0 (functional), a bank's drive enable is the inverse of its enable pin, and its output data is the stored bank contents.
- R3: Changing an enable pin never alters stored contents. The old value reappears when the bank is enabled again.
- R4: A test-clock rising edge with the capture strobe set, in mode 0 or 1, loads the chain with the observed values. With L = 4*DATA_W+6, the layout is:
  - bit L-1: bank A enable pin
  - bit L-2: bank A clock pin
  - bit L-3: bank A internal enable (high = on)
  - bits L-4, L-5 and L-6: the same three signals for bank B
  - bit L-7-i: bank A data input i
  - bit L-7-DATA_W-i: bank B data input i
  - bit 2*DATA_W-1-i: bank A stored bit i
  - bit DATA_W-1-i: bank B stored bit i
- R5: In mode 0 or 1, a test-clock rising edge with the shift strobe set (and capture clear) moves the chain one place toward bit 0. The serial input enters bit L-1, and the serial output always shows bit 0.
- R6: In mode 0 or 1, a falling test-clock edge with the update strobe set copies the chain's enable and output-data cells into the update latches. At all other times the latches hold their value.
- R7: In mode 1 (drive from latches) and mode 2 (clamp), each bank's output data and drive enable come from the update latches. A 1 in an enable cell turns the drive on.
- R8: In mode 0, an update loads the latches without changing the outputs. The loaded values appear as soon as the mode changes to 1.
- R9: In mode 3 (all off), both drive enables are low whatever the latch contents.
- R10: In modes 2 and 3, the capture, shift and update strobes have no effect on the chain or on the latches.
- R11: While test reset is low, the shift stage and the update latches are cleared. In mode 1 this gives zero output data and both drives off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Bank A clock, rising edge |
| clk_b | input | 1 | Bank B clock, rising edge |
| oe_a_n | input | 1 | Bank A output enable pin, active low |
| oe_b_n | input | 1 | Bank B output enable pin, active low |
| din_a | input | DATA_W | Bank A data inputs |
| din_b | input | DATA_W | Bank B data inputs |
| dout_a | output | DATA_W | Bank A output data |
| dout_a_en | output | 1 | Bank A drive enable (0 = high impedance) |
| dout_b | output | DATA_W | Bank B output data |
| dout_b_en | output | 1 | Bank B drive enable (0 = high impedance) |
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Test-logic reset, asynchronous, active low |
| tdi | input | 1 | Serial test data in |
| capture_dr | input | 1 | Capture strobe |
| shift_dr | input | 1 | Shift strobe |
| update_dr | input | 1 | Update strobe |
| mode_sel | input | 2 | 0 functional, 1 drive from latches, 2 clamp, 3 all off |
| tdo | output | 1 | Serial test data out |

## Verification
The bench clocks each bank on its own and toggles the enable pins between clocks. A design that shares clocks, or that clears the flops on disable, shows the wrong bank contents on re-enable. It captures a known pin pattern and shifts it out while shifting a new pattern in. This exposes a reversed or misplaced chain order and a shift in the wrong direction. It also preloads in functional mode and then switches to drive mode, which catches a design that drives from the latches too early or never loads them. Clamp mode gets strobe pulses followed by a readback, and test reset is applied mid-test. A design that lets clamp disturb the chain, or that does not clear to a disabled state, shows stale data or live drivers.

// File: rtl/bscan_pkg.sv
`timescale 1ns/1ps
package bscan_pkg;

    typedef enum logic [1:0] {
        MODE_SYSTEM = 2'd0,
        MODE_EXTEST = 2'd1,
        MODE_CLAMP  = 2'd2,
        MODE_HIGHZ  = 2'd3
    } test_mode_e;

    localparam int NUM_BANKS = 2;

    // Chain length for a given bank width
    function automatic int chain_len(input int w);
        return 4 * w + 6;
    endfunction

    // Control-group positions: bank 0 on top, bank 1 below it
    function automatic int pos_oe_pin(input int b, input int w);
        return 4 * w + 5 - 3 * b;
    endfunction

    function automatic int pos_clk(input int b, input int w);
        return 4 * w + 4 - 3 * b;
    endfunction

    function automatic int pos_en(input int b, input int w);
        return 4 * w + 3 - 3 * b;
    endfunction

    // Data input cells: bank 0 bit 0 just under the control group
    function automatic int pos_din(input int b, input int i, input int w);
        return 4 * w - 1 - b * w - i;
    endfunction

    // Output cells: bank 1 last bit ends at chain bit 0
    function automatic int pos_dout(input int b, input int i, input int w);
        return 2 * w - 1 - b * w - i;
    endfunction

    function automatic logic chain_selected(input test_mode_e m);
        return (m == MODE_SYSTEM) || (m == MODE_EXTEST);
    endfunction

endpackage

// File: rtl/bscan_bank_reg.sv
`timescale 1ns/1ps
module bscan_bank_reg #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [W-1:0] data;
    } bank_st_t;

    bank_st_t st_d;
    bank_st_t st_q;

    always_comb begin
        st_d      = st_q;
        st_d.data = d;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q = st_q.data;

endmodule

// File: rtl/bscan_cell_chain.sv
`timescale 1ns/1ps
module bscan_cell_chain
    import bscan_pkg::*;
#(
    parameter int W = 9,
    parameter int L = 4 * W + 6
) (
    input  logic                           tck,
    input  logic                           trst_n,
    input  logic                           tdi,
    input  logic                           capture_en,
    input  logic                           shift_en,
    input  logic                           update_en,
    input  test_mode_e                     mode,
    input  logic [L-1:0]                   obs,
    output logic                           tdo,
    output logic [NUM_BANKS-1:0]           upd_en,
    output logic [NUM_BANKS-1:0][W-1:0]    upd_data
);

    typedef struct packed {
        logic [L-1:0] stage;
    } stage_st_t;

    typedef struct packed {
        logic [NUM_BANKS-1:0]        en;
        logic [NUM_BANKS-1:0][W-1:0] data;
    } upd_st_t;

    stage_st_t sh_d;
    stage_st_t sh_q;
    upd_st_t   up_d;
    upd_st_t   up_q;
    logic      sel;

    assign sel = chain_selected(mode);

    // Shift stage: capture wins over shift
    always_comb begin
        sh_d = sh_q;
        if (sel && capture_en) begin
            sh_d.stage = obs;
        end else if (sel && shift_en) begin
            sh_d.stage = {tdi, sh_q.stage[L-1:1]};
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    // Update latches: only the controlling cells are kept
    always_comb begin
        up_d = up_q;
        if (sel && update_en) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                up_d.en[b] = sh_q.stage[pos_en(b, W)];
                for (int i = 0; i < W; i++) begin
                    up_d.data[b][i] = sh_q.stage[pos_dout(b, i, W)];
                end
            end
        end
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            up_q <= '0;
        end else begin
            up_q <= up_d;
        end
    end

    assign tdo      = sh_q.stage[0];
    assign upd_en   = up_q.en;
    assign upd_data = up_q.data;

endmodule

// File: rtl/bscan_out_mux.sv
`timescale 1ns/1ps
module bscan_out_mux
    import bscan_pkg::*;
#(
    parameter int W = 9
) (
    input  test_mode_e                     mode,
    input  logic [NUM_BANKS-1:0][W-1:0]    core_q,
    input  logic [NUM_BANKS-1:0]           oe_n,
    input  logic [NUM_BANKS-1:0]           upd_en,
    input  logic [NUM_BANKS-1:0][W-1:0]    upd_data,
    output logic [NUM_BANKS-1:0][W-1:0]    out_data,
    output logic [NUM_BANKS-1:0]           out_en
);

    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            unique case (mode)
                MODE_SYSTEM: begin
                    out_data[b] = core_q[b];
                    out_en[b]   = ~oe_n[b];
                end
                MODE_EXTEST, MODE_CLAMP: begin
                    out_data[b] = upd_data[b];
                    out_en[b]   = upd_en[b];
                end
                default: begin
                    out_data[b] = core_q[b];
                    out_en[b]   = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/bscan_dual_bank.sv
`timescale 1ns/1ps
module bscan_dual_bank
    import bscan_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic              clk_a,
    input  logic              clk_b,
    input  logic              oe_a_n,
    input  logic              oe_b_n,
    input  logic [DATA_W-1:0] din_a,
    input  logic [DATA_W-1:0] din_b,
    output logic [DATA_W-1:0] dout_a,
    output logic              dout_a_en,
    output logic [DATA_W-1:0] dout_b,
    output logic              dout_b_en,
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tdi,
    input  logic              capture_dr,
    input  logic              shift_dr,
    input  logic              update_dr,
    input  logic [1:0]        mode_sel,
    output logic              tdo
);

    localparam int L = chain_len(DATA_W);

    test_mode_e                        mode;
    logic [NUM_BANKS-1:0]              sys_clk;
    logic [NUM_BANKS-1:0]              oe_n;
    logic [NUM_BANKS-1:0][DATA_W-1:0]  sys_din;
    logic [NUM_BANKS-1:0][DATA_W-1:0]  core_q;
    logic [NUM_BANKS-1:0]              upd_en;
    logic [NUM_BANKS-1:0][DATA_W-1:0]  upd_data;
    logic [NUM_BANKS-1:0][DATA_W-1:0]  out_data;
    logic [NUM_BANKS-1:0]              out_en;
    logic [L-1:0]                      obs;

    assign mode    = test_mode_e'(mode_sel);
    assign sys_clk = {clk_b, clk_a};
    assign oe_n    = {oe_b_n, oe_a_n};
    assign sys_din = {din_b, din_a};

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bscan_bank_reg #(.W(DATA_W)) u_bank (
            .clk (sys_clk[b]),
            .d   (sys_din[b]),
            .q   (core_q[b])
        );

        // Observation taps for this bank's cells
        assign obs[pos_oe_pin(b, DATA_W)] = oe_n[b];
        assign obs[pos_clk(b, DATA_W)]    = sys_clk[b];
        assign obs[pos_en(b, DATA_W)]     = ~oe_n[b];
        for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            assign obs[pos_din(b, i, DATA_W)]  = sys_din[b][i];
            assign obs[pos_dout(b, i, DATA_W)] = core_q[b][i];
        end
    end

    bscan_cell_chain #(.W(DATA_W), .L(L)) u_chain (
        .tck        (tck),
        .trst_n     (trst_n),
        .tdi        (tdi),
        .capture_en (capture_dr),
        .shift_en   (shift_dr),
        .update_en  (update_dr),
        .mode       (mode),
        .obs        (obs),
        .tdo        (tdo),
        .upd_en     (upd_en),
        .upd_data   (upd_data)
    );

    bscan_out_mux #(.W(DATA_W)) u_mux (
        .mode     (mode),
        .core_q   (core_q),
        .oe_n     (oe_n),
        .upd_en   (upd_en),
        .upd_data (upd_data),
        .out_data (out_data),
        .out_en   (out_en)
    );

    assign dout_a    = out_data[0];
    assign dout_b    = out_data[1];
    assign dout_a_en = out_en[0];
    assign dout_b_en = out_en[1];

endmodule

// File: rtl/bscan_dual_bank_chk.sv
`timescale 1ns/1ps
module bscan_dual_bank_chk #(
    parameter int W = 9
) (
    input logic         tck,
    input logic         trst_n,
    input logic         clk_a,
    input logic         oe_a_n,
    input logic         oe_b_n,
    input logic [W-1:0] din_a,
    input logic [W-1:0] dout_a,
    input logic         dout_a_en,
    input logic [W-1:0] dout_b,
    input logic         dout_b_en,
    input logic         capture_dr,
    input logic [1:0]   mode_sel,
    input logic         tdo
);

    logic seen_a = 1'b0;

    always_ff @(posedge clk_a) begin
        seen_a <= 1'b1;
    end

    // R1: bank A shows what it stored on its previous clock edge
    p_store_a_r1: assert property (@(posedge clk_a) disable iff (!trst_n)
        (seen_a && mode_sel == 2'd0 && !oe_a_n) |-> dout_a == $past(din_a));

    // R2: functional mode follows the enable pins
    p_system_en_r2: assert property (@(posedge tck) disable iff (!trst_n)
        (mode_sel == 2'd0) |-> (dout_a_en == !oe_a_n) && (dout_b_en == !oe_b_n));

    // R4: after capture, chain bit 0 holds bank B's last stored bit
    p_capture_tdo_r4: assert property (@(posedge tck) disable iff (!trst_n)
        ($past(capture_dr) && $past(mode_sel) == 2'd0 && $past(trst_n))
        |-> tdo == $past(dout_b[W-1]));

    // R9: all-off mode keeps both drives off
    p_highz_off_r9: assert property (@(posedge tck) disable iff (!trst_n)
        (mode_sel == 2'd3) |-> (!dout_a_en && !dout_b_en));

    // R10: clamp outputs never move while clamp persists
    p_clamp_hold_r10: assert property (@(posedge tck) disable iff (!trst_n)
        (mode_sel == 2'd2 && $past(mode_sel) == 2'd2 && $past(trst_n))
        |-> ($stable(dout_a) && $stable(dout_b) && $stable(dout_a_en) && $stable(dout_b_en)));

    // R11: during test reset the latches leave drives off and data zero
    p_rst_clear_r11: assert property (@(posedge tck) disable iff (trst_n)
        (mode_sel == 2'd1) |-> (!dout_a_en && !dout_b_en && dout_a == '0 && dout_b == '0));

endmodule

bind bscan_dual_bank bscan_dual_bank_chk #(.W(DATA_W)) u_chk (
    .tck        (tck),
    .trst_n     (trst_n),
    .clk_a      (clk_a),
    .oe_a_n     (oe_a_n),
    .oe_b_n     (oe_b_n),
    .din_a      (din_a),
    .dout_a     (dout_a),
    .dout_a_en  (dout_a_en),
    .dout_b     (dout_b),
    .dout_b_en  (dout_b_en),
    .capture_dr (capture_dr),
    .mode_sel   (mode_sel),
    .tdo        (tdo)
);

// File: tb/bscan_dual_bank_tb_top.sv
`timescale 1ns/1ps
module bscan_dual_bank_tb_top;

    localparam int TCK_PERIOD = 10;
    localparam int W = 9;
    localparam int L = 4 * W + 6;

    logic         clk_a = 1'b0;
    logic         clk_b = 1'b0;
    logic         oe_a_n = 1'b1;
    logic         oe_b_n = 1'b1;
    logic [W-1:0] din_a = '0;
    logic [W-1:0] din_b = '0;
    logic [W-1:0] dout_a;
    logic         dout_a_en;
    logic [W-1:0] dout_b;
    logic         dout_b_en;
    logic         tck = 1'b0;
    logic         trst_n = 1'b1;
    logic         tdi = 1'b0;
    logic         capture_dr = 1'b0;
    logic         shift_dr = 1'b0;
    logic         update_dr = 1'b0;
    logic [1:0]   mode_sel = 2'd0;
    logic         tdo;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    bscan_dual_bank #(.DATA_W(W)) dut_i (
        .clk_a(clk_a), .clk_b(clk_b), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
        .din_a(din_a), .din_b(din_b), .dout_a(dout_a), .dout_a_en(dout_a_en),
        .dout_b(dout_b), .dout_b_en(dout_b_en), .tck(tck), .trst_n(trst_n),
        .tdi(tdi), .capture_dr(capture_dr), .shift_dr(shift_dr),
        .update_dr(update_dr), .mode_sel(mode_sel), .tdo(tdo)
    );

    always #(TCK_PERIOD / 2) tck = ~tck;

    typedef struct packed {
        logic [1:0]   clk_mask;
        logic         oe_a;
        logic         oe_b;
        logic [W-1:0] d_a;
        logic [W-1:0] d_b;
        logic         en_a;
        logic         en_b;
        logic [W-1:0] q_a;
        logic [W-1:0] q_b;
    } vec_t;

    // R1 bank isolation, R2 enable/data, R3 enable toggles keep contents
    localparam vec_t TBL [8] = '{
        '{2'b11, 1'b0, 1'b0, 9'h1A5, 9'h05A, 1'b1, 1'b1, 9'h1A5, 9'h05A},
        '{2'b01, 1'b0, 1'b0, 9'h0F0, 9'h1FF, 1'b1, 1'b1, 9'h0F0, 9'h05A},
        '{2'b10, 1'b0, 1'b0, 9'h111, 9'h0C3, 1'b1, 1'b1, 9'h0F0, 9'h0C3},
        '{2'b00, 1'b1, 1'b0, 9'h000, 9'h000, 1'b0, 1'b1, 9'h0F0, 9'h0C3},
        '{2'b00, 1'b0, 1'b1, 9'h000, 9'h000, 1'b1, 1'b0, 9'h0F0, 9'h0C3},
        '{2'b01, 1'b1, 1'b1, 9'h155, 9'h000, 1'b0, 1'b0, 9'h155, 9'h0C3},
        '{2'b00, 1'b0, 1'b0, 9'h000, 9'h000, 1'b1, 1'b1, 9'h155, 9'h0C3},
        '{2'b11, 1'b0, 1'b0, 9'h000, 9'h1FF, 1'b1, 1'b1, 9'h000, 9'h1FF}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    function automatic logic [L-1:0] pack(
        input logic oea, input logic clka, input logic ena,
        input logic oeb, input logic clkb, input logic enb,
        input logic [W-1:0] ia, input logic [W-1:0] ib,
        input logic [W-1:0] oa, input logic [W-1:0] ob);
        logic [L-1:0] v;
        v = '0;
        v[L-1] = oea; v[L-2] = clka; v[L-3] = ena;
        v[L-4] = oeb; v[L-5] = clkb; v[L-6] = enb;
        for (int i = 0; i < W; i++) begin
            v[L-7-i]       = ia[i];
            v[L-7-W-i]     = ib[i];
            v[L-7-2*W-i]   = oa[i];
            v[L-7-3*W-i]   = ob[i];
        end
        return v;
    endfunction

    task automatic pulse_clks(input logic [1:0] mask);
        #1;
        clk_a = mask[0];
        clk_b = mask[1];
        #2;
        clk_a = 1'b0;
        clk_b = 1'b0;
        #2;
    endtask

    task automatic strobe_capture();
        @(posedge tck); #1 capture_dr = 1'b1;
        @(posedge tck); #1 capture_dr = 1'b0;
    endtask

    task automatic strobe_update();
        @(posedge tck); #1 update_dr = 1'b1;
        @(posedge tck); #1 update_dr = 1'b0;
    endtask

    task automatic shift_chain(input logic [L-1:0] sin, output logic [L-1:0] sout);
        for (int i = 0; i < L; i++) begin
            @(posedge tck); #1;
            sout[i]  = tdo;
            tdi      = sin[i];
            shift_dr = 1'b1;
        end
        @(posedge tck); #1 shift_dr = 1'b0;
    endtask

    initial begin
        #(TCK_PERIOD * 20000);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [L-1:0] rd;
        logic [L-1:0] p1;
        logic [L-1:0] p2;
        logic [L-1:0] p3;

        #1 trst_n = 1'b0;
        #2;
        // R2: disabled pins give no drive during reset
        check("R2 reset en_a", dout_a_en, 1'b0);
        check("R2 reset en_b", dout_b_en, 1'b0);
        mode_sel = 2'd1;
        #1;
        // R11: cleared latches in drive mode
        check("R11 reset en", {dout_a_en, dout_b_en}, 2'b00);
        check("R11 reset data", {dout_a, dout_b}, '0);
        mode_sel = 2'd0;
        @(posedge tck); #1 trst_n = 1'b1;

        for (int k = 0; k < 8; k++) begin
            oe_a_n = TBL[k].oe_a;
            oe_b_n = TBL[k].oe_b;
            din_a  = TBL[k].d_a;
            din_b  = TBL[k].d_b;
            pulse_clks(TBL[k].clk_mask);
            check("R2 table en_a", dout_a_en, TBL[k].en_a);
            check("R2 table en_b", dout_b_en, TBL[k].en_b);
            if (TBL[k].en_a) check("R1/R3 table dout_a", dout_a, TBL[k].q_a);
            if (TBL[k].en_b) check("R1/R3 table dout_b", dout_b, TBL[k].q_b);
        end

        // R4 capture layout, R5 shift direction
        oe_a_n = 1'b0; oe_b_n = 1'b1;
        din_a = 9'h16B; din_b = 9'h0A6;
        strobe_capture();
        p1 = pack(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, '0, '0, 9'h0AB, 9'h134);
        shift_chain(p1, rd);
        check("R4 R5 captured chain", rd,
              pack(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 9'h16B, 9'h0A6, 9'h000, 9'h1FF));

        // R8: preload in functional mode leaves outputs on the core
        strobe_update();
        check("R8 preload en", {dout_a_en, dout_b_en}, 2'b10);
        check("R8 preload dout_a", dout_a, 9'h000);
        mode_sel = 2'd1;
        #1;
        check("R7 R8 drive en", {dout_a_en, dout_b_en}, 2'b11);
        check("R7 R8 drive data", {dout_a, dout_b}, {9'h0AB, 9'h134});

        // R6: latches hold during shift, then update
        p2 = pack(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, '0, '0, 9'h1F0, 9'h00F);
        shift_chain(p2, rd);
        check("R6 hold during shift", {dout_a, dout_b}, {9'h0AB, 9'h134});
        strobe_update();
        check("R6 updated en", {dout_a_en, dout_b_en}, 2'b01);
        check("R6 updated dout_b", dout_b, 9'h00F);

        // R9: all-off mode
        mode_sel = 2'd3;
        #1;
        check("R9 all off", {dout_a_en, dout_b_en}, 2'b00);

        // R7 clamp drives from latches; R10 strobes ignored
        mode_sel = 2'd2;
        #1;
        check("R7 clamp en", {dout_a_en, dout_b_en}, 2'b01);
        check("R7 clamp dout_b", dout_b, 9'h00F);
        p3 = pack(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0, '0, 9'h0AB, 9'h134);
        shift_chain(p3, rd);
        strobe_capture();
        strobe_update();
        check("R10 clamp en kept", {dout_a_en, dout_b_en}, 2'b01);
        check("R10 clamp data kept", dout_b, 9'h00F);
        mode_sel = 2'd1;
        #1;
        shift_chain(p1, rd);
        check("R10 chain untouched in clamp", rd, p2);

        // R11: mid-test reset
        @(posedge tck); #1 trst_n = 1'b0;
        #1;
        check("R11 reset drives off", {dout_a_en, dout_b_en}, 2'b00);
        check("R11 reset data zero", {dout_a, dout_b}, '0);
        @(posedge tck); #1 trst_n = 1'b1;
        shift_chain('0, rd);
        check("R11 stage cleared", rd, '0);

        finish_run();
    end

endmodule